// File: doc/BRIEF.md
# Dual-Port Constant Multiplier with Half-Size Product Table

This block multiplies two unsigned samples by one fixed signed coefficient in the same clock cycle. For each 4-bit digit it does not keep a full sixteen-word product table. It keeps a shared eight-word table that holds only the even multiples of the coefficient. The upper three bits of a digit pick a table word. When the digit's least significant bit is set, one adder adds the coefficient to that word. A 2:1 select, steered by that bit, then passes either the even word or the sum. No shifter, no address encoder and no zero-masking logic are needed.

Samples wider than four bits are cut into 4-bit digits. Every digit is looked up on its own. Each digit result is weighted by 16 to the power of its position, and the weighted results are summed. Both ports read the one table, so a block doing two-sample work in parallel, such as a 2-D filter with a block size of two, pays for the table once per coefficient. Results are registered, with one cycle of latency and a matching valid flag.

Top module: `dp_even_lut_mul`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `out_valid` = 0 and both products equal to 0. A high `in_valid` during reset has no effect.
- R2: `out_valid` equals the value `in_valid` had one clock edge earlier.
- R3: One cycle after `in_valid` is high, `prod_a` holds `samp_a` × COEF. The sample is unsigned, the coefficient is signed, and the product is two's complement, PROD_W = COEF_W + 4·DIGITS bits wide.
- R4: `prod_b` is formed in the same cycle as `prod_a`, from `samp_b` alone, and it does not depend on `samp_a`. Equal samples on both ports give equal products.
- R5: When `in_valid` is low at an edge, both products keep their previous values whatever the samples are.
- R6: Within a 4-bit digit, bits [3:1] select one of eight stored words, k·2·COEF for k = 0..7. Bit 0 = 1 adds COEF. So digit values 2k and 2k+1 give products that differ by exactly COEF, for all sixteen digit values.
- R7: With DIGITS > 1, digit d (bits [4d+3:4d]) carries weight 16^d. For example, with 8-bit samples, 0x10 gives 16·COEF and 0xF0 gives 240·COEF.
- R8: At the boundaries the product is exact: a zero sample gives 0, and an all-ones sample gives (2^(4·DIGITS) − 1)·COEF with a negative coefficient, without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Samples on both ports are valid this cycle |
| samp_a | input | 4·DIGITS | Unsigned sample, port A |
| samp_b | input | 4·DIGITS | Unsigned sample, port B |
| out_valid | output | 1 | Products hold a new result |
| prod_a | output | COEF_W+4·DIGITS | Signed product of port A |
| prod_b | output | COEF_W+4·DIGITS | Signed product of port B |

## Verification
The hardest case to reach from the ports is the one where every digit position on both ports hits the odd path and the top table word in the same cycle. That case is an all-ones sample, and with a negative coefficient it gives the largest-magnitude product. Random samples reach it only rarely. The stimulus therefore steps a directed sweep through all sixteen digit values in each digit position, with port A and port B using different positions in the same cycle. It also drives the all-ones and zero samples on both ports together. Random pairs are then mixed with idle cycles whose samples change, so that the hold behaviour is checked against products that were really produced.

// File: rtl/dp_even_lut_mul_pkg.sv
// Package: constants shared by the dual-port even-multiple multiplier.
// Assumes digits are always 4 bits, so the even table is always 8 words.
package dp_even_lut_mul_pkg;
    localparam int DIGIT_W     = 4;
    localparam int IDX_W       = DIGIT_W - 1;
    localparam int TABLE_DEPTH = 1 << IDX_W;
    localparam int NUM_PORTS   = 2;
endpackage

// File: rtl/even_mult_table.sv
// Module: even_mult_table
// Builds the eight even multiples 0, 2C, ... 14C of a fixed signed coefficient.
// Assumes the coefficient is a parameter; the words are constants shared by all readers.
module even_mult_table #(
    parameter int                       COEF_W = 8,
    parameter logic signed [COEF_W-1:0] COEF   = -8'sd93,
    localparam int                      ENTRY_W = COEF_W + dp_even_lut_mul_pkg::DIGIT_W
) (
    output logic signed [ENTRY_W-1:0] entry [dp_even_lut_mul_pkg::TABLE_DEPTH]
);
    // One generated word per table slot, value 2*k*C.
    for (genvar k = 0; k < dp_even_lut_mul_pkg::TABLE_DEPTH; k++) begin : g_word
        localparam int signed MULT = 2 * k;
        localparam logic signed [ENTRY_W-1:0] WORD = ENTRY_W'(MULT * int'(COEF));
        assign entry[k] = WORD;
    end
endmodule

// File: rtl/digit_lookup.sv
// Module: digit_lookup
// Multiplies one 4-bit digit by the coefficient: even word read plus optional add of C.
// Assumes the table supplies 2*k*C at index k; no shifter or masking is needed.
module digit_lookup #(
    parameter int                       COEF_W = 8,
    parameter logic signed [COEF_W-1:0] COEF   = -8'sd93,
    localparam int                      ENTRY_W = COEF_W + dp_even_lut_mul_pkg::DIGIT_W
) (
    input  logic [dp_even_lut_mul_pkg::DIGIT_W-1:0] digit,
    input  logic signed [ENTRY_W-1:0]               entry [dp_even_lut_mul_pkg::TABLE_DEPTH],
    output logic signed [ENTRY_W-1:0]               dprod
);
    import dp_even_lut_mul_pkg::*;

    localparam logic signed [ENTRY_W-1:0] C_EXT = ENTRY_W'(COEF);

    logic [IDX_W-1:0]          idx;
    logic signed [ENTRY_W-1:0] even_word;
    logic signed [ENTRY_W-1:0] odd_word;

    // Read port: upper digit bits address the even table, the LSB steers the select.
    always_comb begin
        idx       = digit[DIGIT_W-1:1];
        even_word = entry[idx];
        odd_word  = even_word + C_EXT;
        dprod     = digit[0] ? odd_word : even_word;
    end
endmodule

// File: rtl/digit_combine.sv
// Module: digit_combine
// Weights each digit product by 16^d and sums them into the full-width product.
// Assumes digit 0 is the least significant; digit products are signed.
module digit_combine #(
    parameter int  DIGITS  = 2,
    parameter int  ENTRY_W = 12,
    parameter int  PROD_W  = 16
) (
    input  logic signed [ENTRY_W-1:0] dprod [DIGITS],
    output logic [PROD_W-1:0]         prod
);
    import dp_even_lut_mul_pkg::*;

    logic signed [PROD_W-1:0] acc;

    // Shift-and-add over digit positions.
    always_comb begin
        acc = '0;
        for (int d = 0; d < DIGITS; d++) begin
            acc = acc + (PROD_W'(dprod[d]) <<< (DIGIT_W * d));
        end
        prod = acc;
    end
endmodule

// File: rtl/dp_even_lut_mul.sv
// Module: dp_even_lut_mul (top)
// Two unsigned samples times one fixed signed coefficient per cycle, through one shared
// even-multiple table; results and valid registered with one cycle of latency.
// Assumes synchronous active-low reset and samples that are a whole number of 4-bit digits.
module dp_even_lut_mul #(
    parameter int                       COEF_W = 8,
    parameter logic signed [COEF_W-1:0] COEF   = -8'sd93,
    parameter int                       DIGITS = 2,
    localparam int                      SAMP_W = dp_even_lut_mul_pkg::DIGIT_W * DIGITS,
    localparam int                      PROD_W = COEF_W + SAMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [SAMP_W-1:0] samp_a,
    input  logic [SAMP_W-1:0] samp_b,
    output logic              out_valid,
    output logic [PROD_W-1:0] prod_a,
    output logic [PROD_W-1:0] prod_b
);
    import dp_even_lut_mul_pkg::*;

    localparam int ENTRY_W = COEF_W + DIGIT_W;
    localparam logic signed [ENTRY_W-1:0] C_ENT  = ENTRY_W'(COEF);
    localparam logic signed [PROD_W-1:0]  C_PROD = PROD_W'(COEF);

    logic signed [ENTRY_W-1:0] tbl   [TABLE_DEPTH];
    logic [SAMP_W-1:0]         samp  [NUM_PORTS];
    logic signed [ENTRY_W-1:0] dprod [NUM_PORTS][DIGITS];
    logic [PROD_W-1:0]         prod_next [NUM_PORTS];

    assign samp[0] = samp_a;
    assign samp[1] = samp_b;

    even_mult_table #(.COEF_W(COEF_W), .COEF(COEF)) u_table (.entry(tbl));

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        for (genvar d = 0; d < DIGITS; d++) begin : g_dig
            digit_lookup #(.COEF_W(COEF_W), .COEF(COEF)) u_lookup (
                .digit (samp[p][DIGIT_W*d +: DIGIT_W]),
                .entry (tbl),
                .dprod (dprod[p][d])
            );
            // An odd digit lands exactly one coefficient above its even table word.
            p_odd_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
                samp[p][DIGIT_W*d] |->
                (dprod[p][d] - tbl[samp[p][DIGIT_W*d+1 +: IDX_W]]) == C_ENT);
        end
        digit_combine #(.DIGITS(DIGITS), .ENTRY_W(ENTRY_W), .PROD_W(PROD_W)) u_comb (
            .dprod (dprod[p]),
            .prod  (prod_next[p])
        );
    end

    // Valid pipeline stage.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Product registers: load on valid, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_a <= '0;
            prod_b <= '0;
        end else if (in_valid) begin
            prod_a <= prod_next[0];
            prod_b <= prod_next[1];
        end
    end

    // Reset clears the output state on the following cycle.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && prod_a == '0 && prod_b == '0));

    // Valid flag trails the input flag by one edge.
    p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_valid == $past(in_valid)));

    // Port A product matches a plain multiply of the previous sample.
    p_prod_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> prod_a == PROD_W'($signed(PROD_W'($past(samp_a))) * C_PROD));

    // Port B product matches a plain multiply of its own previous sample.
    p_prod_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> prod_b == PROD_W'($signed(PROD_W'($past(samp_b))) * C_PROD));

    // Idle cycles leave both products untouched.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(prod_a) && $stable(prod_b)));
endmodule

// File: tb/dp_even_lut_mul_tb_top.sv
module dp_even_lut_mul_tb_top;
    localparam int                 COEF_W = 8;
    localparam logic signed [7:0]  COEF   = -8'sd93;
    localparam int                 COEF_I = -93;
    localparam int                 DIGITS = 2;
    localparam int                 SAMP_W = 4 * DIGITS;
    localparam int                 PROD_W = COEF_W + SAMP_W;
    localparam int                 SAMP_MAX = (1 << SAMP_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [SAMP_W-1:0] samp_a = '0;
    logic [SAMP_W-1:0] samp_b = '0;
    logic              out_valid;
    logic [PROD_W-1:0] prod_a;
    logic [PROD_W-1:0] prod_b;

    int n_cmp = 0;
    int n_bad = 0;
    int last_a = 0;
    int last_b = 0;

    always #2 clk = ~clk;

    dp_even_lut_mul #(.COEF_W(COEF_W), .COEF(COEF), .DIGITS(DIGITS)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .samp_a(samp_a), .samp_b(samp_b),
        .out_valid(out_valid), .prod_a(prod_a), .prod_b(prod_b)
    );

    function automatic int ref_mul(input int s);
        return s * COEF_I;
    endfunction

    function automatic int as_int(input logic [PROD_W-1:0] v);
        return int'($signed(v));
    endfunction

    task automatic check(input string req, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Drive one cycle at the falling edge, then check after the next rising edge.
    task automatic step(input logic v, input int a, input int b, input string req);
        @(negedge clk);
        in_valid = v;
        samp_a   = SAMP_W'(a);
        samp_b   = SAMP_W'(b);
        @(negedge clk);
        check({req, " valid"}, int'(out_valid), int'(v));
        if (v) begin
            last_a = ref_mul(a);
            last_b = ref_mul(b);
        end
        check({req, " port A"}, as_int(prod_a), last_a);
        check({req, " port B"}, as_int(prod_b), last_b);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        // R1: reset with in_valid high must still clear outputs.
        rst_n = 1'b0;
        in_valid = 1'b1;
        samp_a = 8'hAB;
        samp_b = 8'h37;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", int'(out_valid), 0);
        check("R1 prod_a in reset", as_int(prod_a), 0);
        check("R1 prod_b in reset", as_int(prod_b), 0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R8 boundaries: zero and all-ones on both ports.
        step(1'b1, 0, SAMP_MAX, "R8 zero/max");
        step(1'b1, SAMP_MAX, 0, "R8 max/zero");
        step(1'b1, SAMP_MAX, SAMP_MAX, "R8 max/max");
        // R4: equal samples on both ports, and port independence.
        step(1'b1, 8'h5C, 8'h5C, "R4 equal");
        step(1'b1, 8'h5C, 8'h01, "R4 independent");
        // R6: every digit value in the low position on A, high position on B.
        for (int dv = 0; dv < 16; dv++) begin
            step(1'b1, dv, dv << 4, "R6 digit sweep");
        end
        // R7: digit weighting.
        step(1'b1, 8'h10, 8'hF0, "R7 weight");
        step(1'b1, 8'h0F, 8'hFF, "R7 mixed");
        // R5: idle cycles with changing samples hold the products.
        step(1'b1, 8'h3D, 8'hC2, "R3 load");
        step(1'b0, 8'hFF, 8'h00, "R5 hold");
        step(1'b0, 8'h12, 8'h99, "R5 hold again");
        // R2/R3/R4: random mix of active and idle cycles.
        for (int i = 0; i < 400; i++) begin
            logic v;
            v = ($urandom % 4) != 0;
            step(v, int'($urandom % (SAMP_MAX + 1)), int'($urandom % (SAMP_MAX + 1)),
                 v ? "R3 random" : "R2 random idle");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule